// File: doc/BRIEF.md
# Parallel Multi-Channel Asynchronous Serial Transmitter

This block drives up to thirty-two asynchronous serial lines from one shared frame engine. Each channel has an eight-byte queue that software or a neighbouring block fills through a per-channel write strobe. A staging register collects at most one byte per channel. A transpose network turns the staged bytes into eight bit-slice words, so that word k holds bit k of every channel. When a frame starts, the engine copies the staged set into a second register bank. For each of the ten bit periods it then applies one full-width word to every line at the same time, so no line is skewed against another.

Bit timing comes from a single-cycle `bit_tick` pulse made by an external baud generator. A line changes only in the cycle after a sampled tick, whatever the data or the number of channels in use. While the current frame is on the wire, the staging register keeps filling from the queues. The tick that ends a stop bit therefore starts the next frame at once, with no idle period between frames.

Top module: `ptx_parallel_uart`

## Requirements
- R1: After synchronous reset, every line of `tx_out` is high and `tx_busy`, `tx_pending` and `buf_full` are all zero.
- R2: A frame is ten bit periods long: a low start bit, then eight data bits with bit 0 first, then a high stop bit. Each period runs from one sampled `bit_tick` to the next.
- R3: Each channel queue holds eight bytes. `buf_full[n]` is high while channel n's queue holds eight bytes. A write to a full queue is dropped, and that byte is never transmitted.
- R4: `tx_out` changes only in the cycle after a sampled `bit_tick`, and all lines change together. A period's level on line n comes from bit n of one shared slice word, where bit n of word k is bit k of channel n's byte.
- R5: A channel with no staged byte when a frame starts sends no start bit. Its line stays high for the whole frame and its `tx_busy` bit stays low. The other channels send normally.
- R6: A channel with `ch_enable[n]` low is never staged. Its queued bytes are kept, and it sends them once it is enabled again.
- R7: A byte written at least two cycles before a frame-starting tick belongs to that frame. After the first frame starts, the next byte of every channel is staged during that frame. The tick that ends the stop bit then starts the next frame, with no gap.
- R8: When nothing is staged at the tick that ends a stop bit, the engine goes idle: all lines are high and `tx_busy` is zero. The next sampled tick with staged data starts a frame.
- R9: `tx_busy[n]` is high for the ten bit periods of a frame that carries channel n. `tx_pending[n]` is high while channel n has a queued or staged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse that marks each bit-period boundary |
| ch_enable | input | NUM_CH | Per-channel permission to stage bytes |
| wr_en | input | NUM_CH | Per-channel queue write strobe |
| wr_data | input | NUM_CH*8 | Write bytes; channel n is bits 8n+7 down to 8n |
| buf_full | output | NUM_CH | Channel queue holds eight bytes |
| tx_pending | output | NUM_CH | Channel has a byte queued or staged |
| tx_busy | output | NUM_CH | Channel is part of the frame on the wire |
| tx_out | output | NUM_CH | Serial lines, idle high |

## Verification
A byte written at clock edge E lands in its queue at E. It is staged at E+1, and a tick sampled at E+2 or later starts its frame. The bench therefore leaves at least one free cycle between a write and the next tick. A tick sampled at an edge changes `tx_out` and `tx_busy` at that same edge. The bench drives each tick on a falling edge and compares the lines on the next falling edge. It then compares them again on the two falling edges that follow, before the next tick, to show that each level holds steady for the whole four-cycle period. `buf_full` is read half a cycle after the write edge that fills the queue.

// File: rtl/ptx_pkg.sv
// Shared constants and types for the parallel serial transmitter.
// Assumes an 8-bit payload framed by one start bit and one stop bit.
package ptx_pkg;
    parameter int unsigned BYTE_W    = 8;
    localparam int unsigned FRAME_LEN = BYTE_W + 2;
    localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
    localparam int unsigned SEL_W     = $clog2(BYTE_W);
    typedef logic [IDX_W-1:0] bit_idx_t;
endpackage

// File: rtl/ptx_chan_fifo.sv
// Per-channel byte queue. Writes to a full queue and reads from an empty
// queue are dropped. Assumes DEPTH >= 2. The head byte is shown while the
// queue is not empty.
module ptx_chan_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Advance the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end
endmodule

// File: rtl/ptx_transpose.sv
// Bit-matrix transpose: word k of the output collects bit k of every
// channel byte. Pure wiring, no logic depth.
module ptx_transpose #(
    parameter int unsigned CH = 32,
    parameter int unsigned W  = 8
) (
    input  logic [CH-1:0][W-1:0] bytes_in,
    output logic [W-1:0][CH-1:0] slices_out
);
    for (genvar k = 0; k < W; k++) begin : g_word
        for (genvar n = 0; n < CH; n++) begin : g_bit
            assign slices_out[k][n] = bytes_in[n][k];
        end
    end
endmodule

// File: rtl/ptx_bit_engine.sv
// Frame engine. It holds the active slice set and the active channel mask,
// and counts bit periods on bit_tick. It takes the staged set on the tick
// that ends a stop bit, or on any tick while idle. Assumes bit_tick is a
// single-cycle pulse.
module ptx_bit_engine
    import ptx_pkg::*;
#(
    parameter int unsigned CH = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bit_tick,
    input  logic [BYTE_W-1:0][CH-1:0] stg_slices,
    input  logic [CH-1:0]             stg_mask,
    output logic                      load,
    output logic [CH-1:0]             tx_out,
    output logic [CH-1:0]             busy
);
    logic [BYTE_W-1:0][CH-1:0] cur;
    logic [CH-1:0]             active;
    logic                      running;
    bit_idx_t                  idx;
    logic [CH-1:0]             level;
    logic [SEL_W-1:0]          sel;

    assign load = bit_tick && (!running || idx == bit_idx_t'(FRAME_LEN - 1));
    assign sel  = SEL_W'(idx - bit_idx_t'(1));

    // Take a new frame at a boundary, otherwise step the bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur     <= '0;
            active  <= '0;
            running <= 1'b0;
            idx     <= '0;
        end else if (load) begin
            cur     <= stg_slices;
            active  <= stg_mask;
            running <= |stg_mask;
            idx     <= '0;
        end else if (bit_tick && running) begin
            idx <= idx + 1'b1;
        end
    end

    // Pick the shared word for the current bit period.
    always_comb begin
        if (idx == '0)                                level = '0;
        else if (idx == bit_idx_t'(FRAME_LEN - 1))    level = '1;
        else                                          level = cur[sel];
    end

    // Lines outside the frame stay at the idle level.
    assign tx_out = running ? (level | ~active) : '1;
    assign busy   = running ? active : '0;
endmodule

// File: rtl/ptx_parallel_uart.sv
// Top level of the parallel transmitter: one queue per channel, a staging
// bank that collects one byte per enabled channel until the next frame
// starts, the transpose network, and the shared frame engine. Assumes the
// external baud generator spaces bit_tick pulses at least two cycles apart.
module ptx_parallel_uart
    import ptx_pkg::*;
#(
    parameter int unsigned NUM_CH     = 32,
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_tick,
    input  logic [NUM_CH-1:0]        ch_enable,
    input  logic [NUM_CH-1:0]        wr_en,
    input  logic [NUM_CH*BYTE_W-1:0] wr_data,
    output logic [NUM_CH-1:0]        buf_full,
    output logic [NUM_CH-1:0]        tx_pending,
    output logic [NUM_CH-1:0]        tx_busy,
    output logic [NUM_CH-1:0]        tx_out
);
    logic [NUM_CH-1:0][BYTE_W-1:0] head;
    logic [NUM_CH-1:0][BYTE_W-1:0] stg_bytes;
    logic [BYTE_W-1:0][NUM_CH-1:0] stg_slices;
    logic [NUM_CH-1:0]             stg_mask;
    logic [NUM_CH-1:0]             q_empty;
    logic [NUM_CH-1:0]             take;
    logic                          load;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        ptx_chan_fifo #(
            .DEPTH (FIFO_DEPTH),
            .W     (BYTE_W)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (wr_en[n]),
            .din   (wr_data[n*BYTE_W +: BYTE_W]),
            .pop   (take[n]),
            .dout  (head[n]),
            .empty (q_empty[n]),
            .full  (buf_full[n])
        );

        assign take[n] = !stg_mask[n] && !q_empty[n] && ch_enable[n] && !load;

        // Fill this channel's staging slot, and clear it when a frame starts.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_mask[n]  <= 1'b0;
                stg_bytes[n] <= '0;
            end else if (load) begin
                stg_mask[n]  <= 1'b0;
            end else if (take[n]) begin
                stg_mask[n]  <= 1'b1;
                stg_bytes[n] <= head[n];
            end
        end
    end

    assign tx_pending = ~q_empty | stg_mask;

    ptx_transpose #(
        .CH (NUM_CH),
        .W  (BYTE_W)
    ) u_xpose (
        .bytes_in   (stg_bytes),
        .slices_out (stg_slices)
    );

    ptx_bit_engine #(
        .CH (NUM_CH)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .stg_slices (stg_slices),
        .stg_mask   (stg_mask),
        .load       (load),
        .tx_out     (tx_out),
        .busy       (tx_busy)
    );
endmodule

// File: rtl/ptx_uart_checker.sv
// Protocol checker for the parallel transmitter. It is attached to the top
// module by the bind statement at the end of this file.
module ptx_uart_checker #(
    parameter int unsigned NUM_CH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_tick,
    input logic [NUM_CH-1:0] tx_out,
    input logic [NUM_CH-1:0] tx_busy,
    input logic [NUM_CH-1:0] buf_full,
    input logic [NUM_CH-1:0] tx_pending
);
    // R4: the lines move only in the cycle after a sampled tick
    assert_tx_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(tx_out));

    // R2: a channel that joins a frame does so on a tick, with a low start bit
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_busy & ~$past(tx_busy)) != '0) |->
            ($past(bit_tick) && ((tx_busy & ~$past(tx_busy) & tx_out) == '0)));

    // R5: a line that is not part of the frame is high
    assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (~tx_out & ~tx_busy) == '0);

    // R3: a full queue always counts as pending work
    assert_full_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full & ~tx_pending) == '0);
endmodule

bind ptx_parallel_uart ptx_uart_checker #(.NUM_CH(NUM_CH)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .tx_out     (tx_out),
    .tx_busy    (tx_busy),
    .buf_full   (buf_full),
    .tx_pending (tx_pending)
);

// File: tb/test_ptx_parallel_uart.sv
module test_ptx_parallel_uart;
    localparam int CH = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic [CH-1:0] ch_enable = '1;
    logic [CH-1:0] wr_en = '0;
    logic [CH*8-1:0] wr_data = '0;
    logic [CH-1:0] buf_full, tx_pending, tx_busy, tx_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ptx_parallel_uart i_ptx_parallel_uart (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ch_enable(ch_enable),
        .wr_en(wr_en), .wr_data(wr_data), .buf_full(buf_full),
        .tx_pending(tx_pending), .tx_busy(tx_busy), .tx_out(tx_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected line word for bit period i of a frame carrying mask m.
    function automatic logic [31:0] exp_word(int i, logic [31:0] m, logic [CH-1:0][7:0] b);
        logic [31:0] w;
        for (int n = 0; n < CH; n++) begin
            if (!m[n])          w[n] = 1'b1;
            else if (i == 0)    w[n] = 1'b0;
            else if (i == 9)    w[n] = 1'b1;
            else                w[n] = b[n][i-1];
        end
        return w;
    endfunction

    task automatic tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic write_bytes(logic [31:0] m, logic [CH-1:0][7:0] b);
        @(negedge clk);
        wr_en = m;
        wr_data = b;
        @(negedge clk);
        wr_en = '0;
        @(negedge clk);
    endtask

    // Start a frame with a tick and check all ten periods at three points each.
    task automatic run_frame(string req, logic [31:0] m, logic [CH-1:0][7:0] b);
        for (int i = 0; i < 10; i++) begin
            tick();
            for (int s = 0; s < 3; s++) begin
                chk(req, tx_out, exp_word(i, m, b));
                if (s < 2) @(negedge clk);
            end
            if (i == 0) chk("R9 busy", tx_busy, m);
        end
    endtask

    task automatic end_idle();
        tick();
        chk("R8 idle lines", tx_out, '1);
        chk("R8 idle busy", tx_busy, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CH-1:0][7:0] b, b2;
        logic [31:0] m;
        void'($urandom(32'd20150901));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_out", tx_out, '1);
        chk("R1 busy", tx_busy, '0);
        chk("R1 pending", tx_pending, '0);
        chk("R1 full", buf_full, '0);

        // R2 R4: all channels, all zero then all ones
        b = '0;
        write_bytes('1, b);
        run_frame("R2 zeros", '1, b);
        end_idle();
        b = '1;
        write_bytes('1, b);
        run_frame("R4 ones", '1, b);
        end_idle();

        // R5: only channel 31 carries data
        b = '0; b[31] = 8'hA5;
        write_bytes(32'h8000_0000, b);
        run_frame("R5 single", 32'h8000_0000, b);
        end_idle();

        // R2 R5: random subsets and bytes
        for (int r = 0; r < 8; r++) begin
            m = $urandom() | (32'h1 << ($urandom() % 32));
            for (int n = 0; n < CH; n++) b[n] = 8'($urandom());
            write_bytes(m, b);
            run_frame("R5 random", m, b);
            end_idle();
        end

        // R7: two bytes per channel go out back to back
        m = $urandom() | 32'h1;
        for (int n = 0; n < CH; n++) begin
            b[n] = 8'($urandom());
            b2[n] = 8'($urandom());
        end
        write_bytes(m, b);
        write_bytes(m, b2);
        run_frame("R7 first", m, b);
        run_frame("R7 second", m, b2);
        end_idle();
        chk("R9 pending drained", tx_pending, '0);

        // R3 R6: channel 0 held off while its queue overfills
        ch_enable = 32'hFFFF_FFFE;
        for (int k = 0; k < 9; k++) begin
            b = '0;
            b[0] = 8'(8'h10 + k);
            @(negedge clk);
            wr_en = 32'h1;
            wr_data = b;
            @(negedge clk);
            wr_en = '0;
            if (k == 6) chk("R3 not yet full", {31'b0, buf_full[0]}, 32'h0);
            if (k == 7) chk("R3 full at eight", {31'b0, buf_full[0]}, 32'h1);
        end
        chk("R3 still full", {31'b0, buf_full[0]}, 32'h1);
        chk("R6 pending held", {31'b0, tx_pending[0]}, 32'h1);
        // other channels send while channel 0 stays high
        m = 32'h0000_F0F0;
        for (int n = 0; n < CH; n++) b[n] = 8'($urandom());
        write_bytes(m, b);
        run_frame("R6 disabled stays high", m, b);
        end_idle();
        chk("R6 pending kept", {31'b0, tx_pending[0]}, 32'h1);
        // enable: exactly eight bytes 0x10..0x17, the ninth was dropped
        ch_enable = '1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            b = '0;
            b[0] = 8'(8'h10 + k);
            run_frame("R3 drained byte", 32'h1, b);
        end
        end_idle();
        chk("R3 ninth byte dropped", {31'b0, tx_pending[0]}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule